// File: doc/BRIEF.md
# Serial-In Display Driver Register

This block drives the digit, segment or dot lines of a multiplexed vacuum fluorescent display from a three-wire serial link. A host frames each transfer with an enable strobe. While the strobe is high, each rising edge of the serial clock shifts one data bit into a 20-stage shift register. When the strobe drops, the whole register is copied into a parallel output latch, and the output lines then follow the latch. A blanking input turns every output line off at once. The latch keeps its contents while blanking is active, so the display returns unchanged when blanking is released.

The serial pins are asynchronous to the chip. The three serial inputs pass through two-flop synchronizers into the system clock domain. Their edges are then detected as one-cycle pulses. A serial output carries the bit at the far end of the shift register, so several drivers can be chained on one data line. To clear a driver, the host shifts in 20 zeros inside one enable window and then drops enable.

Top module: `serial_disp_drv`

## Requirements
- R1: After reset, all 20 output lines, the shift register contents and `ser_dout` are 0.
- R2: The shift register moves only on a rising `ser_clk` edge while `ser_en` is high. Serial clock edges while `ser_en` is low change neither the register, the latch nor `ser_dout`.
- R3: On the falling edge of `ser_en`, the register is copied to the latch. For a 20-bit frame, `drv_out[k]` then shows the (k+1)-th bit shifted in, so the first bit lands on `drv_out[0]`. A 1 drives a line on and a 0 drives it off.
- R4: While a transfer is in progress, `drv_out` keeps showing the previously latched frame.
- R5: While `blank` is 1, `drv_out` is all zeros. When `blank` returns to 0, the unchanged latch contents reappear.
- R6: `ser_dout` changes only on a falling `ser_clk` edge inside an enable window. At that edge it takes the bit in the last stage, which is the bit the next rising edge pushes out.
- R7: If more than 20 bits are shifted in one window, only the last 20 are latched. The earlier bits leave through `ser_dout` in the order they were sent.
- R8: Shifting 20 zeros in one window and then dropping `ser_en` turns every output line off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_en | input | 1 | Transfer frame strobe; its falling edge loads the latch |
| ser_din | input | 1 | Serial data input |
| blank | input | 1 | Forces all output lines off while high |
| ser_dout | output | 1 | Cascade output: the bit in the last stage of the shift register |
| drv_out | output | 20 | Output line states; bit 0 is output 1 |

## Verification
The assertions check the following on every cycle:
- Blanking forces every output line to zero.
- The shift register stays still outside an enable window.
- The latch changes only on an enable falling edge, and then takes the register value.
- `ser_dout` moves only on a serial clock falling edge.

Only the bench scenarios can show the bit ordering: the first bit lands on output 1, an overflowing frame keeps its last 20 bits, and the overflow bits leave on `ser_dout` in order. The same holds for the zero-flush clearing the display and for blanked contents reappearing intact.

// File: rtl/serial_disp_drv.sv
module serial_disp_drv #(
  parameter int WIDTH       = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_clk,
  input  logic             ser_en,
  input  logic             ser_din,
  input  logic             blank,
  output logic             ser_dout,
  output logic [WIDTH-1:0] drv_out
);

  logic [SYNC_STAGES:0]   clk_pipe;
  logic [SYNC_STAGES:0]   en_pipe;
  logic [SYNC_STAGES-1:0] din_pipe;
  logic [WIDTH-1:0]       sr;
  logic [WIDTH-1:0]       latch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_pipe <= '0;
      en_pipe  <= '0;
      din_pipe <= '0;
    end else begin
      clk_pipe <= {clk_pipe[SYNC_STAGES-1:0], ser_clk};
      en_pipe  <= {en_pipe[SYNC_STAGES-1:0], ser_en};
      din_pipe <= {din_pipe[SYNC_STAGES-2:0], ser_din};
    end
  end

  wire clk_s    = clk_pipe[SYNC_STAGES-1];
  wire en_s     = en_pipe[SYNC_STAGES-1];
  wire din_s    = din_pipe[SYNC_STAGES-1];
  wire clk_rise = clk_s & ~clk_pipe[SYNC_STAGES];
  wire clk_fall = ~clk_s & clk_pipe[SYNC_STAGES];
  wire en_fall  = ~en_s & en_pipe[SYNC_STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr       <= '0;
      latch    <= '0;
      ser_dout <= 1'b0;
    end else begin
      if (en_s && clk_rise) sr <= {din_s, sr[WIDTH-1:1]};
      if (en_s && clk_fall) ser_dout <= sr[0];
      if (en_fall) latch <= sr;
    end
  end

  assign drv_out = blank ? '0 : latch;

endmodule

// File: rtl/serial_disp_drv_checker.sv
module serial_disp_drv_checker #(
  parameter int WIDTH = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             blank,
  input logic             ser_dout,
  input logic [WIDTH-1:0] drv_out,
  input logic             en_s,
  input logic             en_fall,
  input logic             clk_fall,
  input logic [WIDTH-1:0] sr,
  input logic [WIDTH-1:0] latch
);

  AST_BLANK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> drv_out == '0); // R5

  AST_NO_SHIFT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en_s |=> $stable(sr)); // R2

  AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    en_fall |=> latch == $past(sr)); // R3

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en_fall |=> $stable(latch)); // R4

  AST_DOUT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_fall |=> $stable(ser_dout)); // R6

endmodule

bind serial_disp_drv serial_disp_drv_checker #(.WIDTH(WIDTH)) i_chk (
  .clk(clk), .rst_n(rst_n), .blank(blank), .ser_dout(ser_dout),
  .drv_out(drv_out), .en_s(en_s), .en_fall(en_fall), .clk_fall(clk_fall),
  .sr(sr), .latch(latch)
);

// File: tb/test_serial_disp_drv.sv
module test_serial_disp_drv;
  localparam int W = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_en = 1'b0, ser_din = 1'b0, blank = 1'b0;
  logic ser_dout;
  logic [W-1:0] drv_out;

  int checks = 0, errors = 0;
  logic [W-1:0] model_sr = '0, model_latch = '0;
  logic model_dout = 1'b0;
  logic [W-1:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  serial_disp_drv i_serial_disp_drv (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_en(ser_en),
    .ser_din(ser_din), .blank(blank), .ser_dout(ser_dout), .drv_out(drv_out)
  );

  task automatic check(input string r, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    ser_din = b;
    wait_cyc(3);
    ser_clk = 1'b1;
    model_sr = {b, model_sr[W-1:1]};
    wait_cyc(4);
    check("R6 dout held until clock fall", {{(W-1){1'b0}}, ser_dout}, {{(W-1){1'b0}}, model_dout});
    ser_clk = 1'b0;
    wait_cyc(4);
    model_dout = model_sr[0];
    check("R6 dout after clock fall", {{(W-1){1'b0}}, ser_dout}, {{(W-1){1'b0}}, model_dout});
  endtask

  task automatic send_seq(input logic [63:0] bits, input int n, input string r);
    ser_en = 1'b1;
    wait_cyc(3);
    for (int i = 0; i < n; i++) begin
      send_bit(bits[i]);
      if (i == n / 2) check("R4 old frame shown during transfer", drv_out, model_latch);
    end
    wait_cyc(2);
    model_latch = model_sr;
    exp_q.push_back(model_latch);
    tag_q.push_back(r);
    ser_en = 1'b0;
    wait_cyc(8);
  endtask

  initial begin
    forever begin
      @(negedge ser_en);
      repeat (5) @(negedge clk);
      if (exp_q.size() > 0) check(tag_q.pop_front(), drv_out, exp_q.pop_front());
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait_cyc(5);
    check("R1 outputs after reset", drv_out, '0);
    check("R1 dout after reset", {{(W-1){1'b0}}, ser_dout}, '0);
    rst_n = 1'b1;
    wait_cyc(3);

    send_seq(64'h0_5C3A1, W, "R3 first bit on drv_out[0]");
    send_seq(64'h0_F00FF, W, "R3 second frame");

    blank = 1'b1;
    wait_cyc(2);
    check("R5 blank forces off", drv_out, '0);
    blank = 1'b0;
    wait_cyc(1);
    check("R5 contents reappear", drv_out, model_latch);

    for (int i = 0; i < 5; i++) begin
      ser_din = i[0];
      wait_cyc(3);
      ser_clk = 1'b1;
      wait_cyc(4);
      ser_clk = 1'b0;
      wait_cyc(4);
    end
    check("R2 outputs unchanged by idle clocks", drv_out, model_latch);
    check("R2 dout unchanged by idle clocks", {{(W-1){1'b0}}, ser_dout}, {{(W-1){1'b0}}, model_dout});
    send_seq(64'h0, 0, "R2 register untouched by idle clocks");

    send_seq(64'h1_2345_6789_ABCDE, W + 5, "R7 last 20 of 25 bits latched");
    send_seq(64'h0, W, "R8 zero flush clears outputs");
    check("R8 outputs off", drv_out, '0);

    wait_cyc(5);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule